// File: doc/BRIEF.md
# SMBus Byte-Write Register Receiver

This block is a target on a two-wire SMBus/I2C bus that accepts only byte-write transactions. The block samples SCL and SDA with the system clock and finds start and stop conditions. It then collects a 7-bit target address, the direction bit, a command byte and a data byte. It acknowledges each byte by pulling SDA low through an open-drain enable. The command byte selects one of four destinations: a command register, two message bytes, and a 4-bit frequency-strap field. Every other command value is reserved and is acknowledged, but it is not stored.

The host side reads the stored values directly from output ports. When a stored value changes, a one-cycle strobe fires together with the command value that caused the change. The host can use the strobe to learn that new data has arrived. A later write to a message byte replaces the earlier value, even if the host has not read it yet. Nothing protects a host read that happens at the same time as an update.

Top module: `smb_bytewr_slave`

## Requirements
- R1: After reset, all four stored values read zero, SDA is not driven (`sda_oe_o` = 0) and `wr_stb_o` is low.
- R2: When the address byte carries the programmed 7-bit address and a direction bit of 0, the block pulls SDA low during the ACK clock of the address byte, the command byte and the data byte. This applies to reserved command values as well.
- R3: When the address does not match, the block gives no ACK and ignores the rest of the transaction, and no stored value changes.
- R4: When the direction bit is 1, the block gives no ACK and no stored value changes.
- R5: Command 0x00 stores the data byte in the command register. Command 0x04 stores it in message byte 0. Command 0x05 stores it in message byte 1.
- R6: Command 0x08 stores data bits 3:0 as the strap field. Data bits 7:4 have no effect on the stored value.
- R7: A write that carries any other command value leaves all stored values unchanged and raises no strobe.
- R8: A second write to a message byte replaces its earlier value unconditionally.
- R9: A stop that arrives before the ACK of the data byte discards the transaction, and nothing is stored.
- R10: A repeated start at any point restarts address reception. A complete frame that follows it is accepted normally.
- R11: Each stored update raises `wr_stb_o` for exactly one clock cycle, with `wr_idx_o` equal to the command value, and produces exactly one strobe per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr_i | input | 7 | Programmed target address |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK) |
| cmd_reg_o | output | 8 | Command register contents |
| msg0_o | output | 8 | Message byte 0 |
| msg1_o | output | 8 | Message byte 1 |
| strap_o | output | 4 | Frequency-strap field |
| wr_stb_o | output | 1 | One-cycle update strobe |
| wr_idx_o | output | 8 | Command value of the update |

## Verification
The bench drives reserved command values near the valid ones (3, 6, 9 and 0xFF). A decoder that compares only part of the command byte would alias these writes onto real registers and change a stored value. The bench also sends strap writes with the upper nibble set, which would corrupt a strap field that is too wide. It sends stops in the middle of the data byte and repeated starts after a mismatched address and in the middle of the command byte. A design that commits too early, or that stays stuck ignoring the bus, would store the aborted data or miss the frame that follows. Read requests and foreign addresses are checked for the absence of any ACK and for unchanged state.

// File: rtl/smb_bw_pkg.sv
package smb_bw_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int STRAP_W  = 4;
    localparam int BITCNT_W = $clog2(BYTE_W);

    // Command values that select a stored destination
    localparam logic [BYTE_W-1:0] CMD_CTRL  = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_MSG0  = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_MSG1  = 8'h05;
    localparam logic [BYTE_W-1:0] CMD_STRAP = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_IGNORE
    } frame_state_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_CMD,
        BY_DATA
    } byte_slot_e;

    typedef struct packed {
        logic [BYTE_W-1:0]  ctrl;
        logic [BYTE_W-1:0]  msg0;
        logic [BYTE_W-1:0]  msg1;
        logic [STRAP_W-1:0] strap;
        logic               stb;
        logic [BYTE_W-1:0]  idx;
    } reg_bank_t;

endpackage

// File: rtl/smb_bw_sync.sv
module smb_bw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_chain;
        logic [STAGES-1:0] sda_chain;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    logic scl_now, sda_now;

    always_comb begin
        s_d = s_q;
        s_d.scl_chain = {s_q.scl_chain[STAGES-2:0], scl_i};
        s_d.sda_chain = {s_q.sda_chain[STAGES-2:0], sda_i};
        s_d.scl_prev  = s_q.scl_chain[STAGES-1];
        s_d.sda_prev  = s_q.sda_chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{scl_chain: '1, sda_chain: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_now = s_q.scl_chain[STAGES-1];
    assign sda_now = s_q.sda_chain[STAGES-1];

    assign scl_o   = scl_now;
    assign sda_o   = sda_now;
    assign rise_o  = scl_now & ~s_q.scl_prev;
    assign fall_o  = ~scl_now & s_q.scl_prev;
    assign start_o = scl_now & s_q.scl_prev & s_q.sda_prev & ~sda_now;
    assign stop_o  = scl_now & s_q.scl_prev & ~s_q.sda_prev & sda_now;

endmodule

// File: rtl/smb_bw_frame.sv
module smb_bw_frame
    import smb_bw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              sda_s_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              sda_oe_o,
    output logic              commit_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [BYTE_W-1:0] data_o
);

    typedef struct packed {
        frame_state_e        state;
        byte_slot_e          slot;
        logic [BITCNT_W-1:0] bit_cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   cmd;
        logic [BYTE_W-1:0]   data;
        logic                commit;
    } frame_t;

    frame_t f_d, f_q;

    logic [BYTE_W-1:0] full_byte;
    logic              last_bit;
    logic              addr_hit;

    assign full_byte = {f_q.shreg[BYTE_W-2:0], sda_s_i};
    assign last_bit  = (f_q.bit_cnt == BITCNT_W'(BYTE_W - 1));
    assign addr_hit  = (full_byte[BYTE_W-1:1] == own_addr_i) && !full_byte[0];

    always_comb begin
        f_d        = f_q;
        f_d.commit = 1'b0;
        if (start_i) begin
            f_d.state   = ST_RX;
            f_d.slot    = BY_ADDR;
            f_d.bit_cnt = '0;
        end else if (stop_i) begin
            f_d.state = ST_IDLE;
        end else begin
            unique case (f_q.state)
                ST_RX: begin
                    if (rise_i) begin
                        f_d.shreg   = full_byte;
                        f_d.bit_cnt = f_q.bit_cnt + 1'b1;
                        if (last_bit) begin
                            unique case (f_q.slot)
                                BY_ADDR: f_d.state = addr_hit ? ST_ACK_WAIT : ST_IGNORE;
                                BY_CMD: begin
                                    f_d.cmd   = full_byte;
                                    f_d.state = ST_ACK_WAIT;
                                end
                                default: begin
                                    f_d.data  = full_byte;
                                    f_d.state = ST_ACK_WAIT;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (fall_i) f_d.state = ST_ACK_LO;
                end
                ST_ACK_LO: begin
                    if (rise_i) f_d.state = ST_ACK_HI;
                end
                ST_ACK_HI: begin
                    if (fall_i) begin
                        f_d.bit_cnt = '0;
                        unique case (f_q.slot)
                            BY_ADDR: begin
                                f_d.slot  = BY_CMD;
                                f_d.state = ST_RX;
                            end
                            BY_CMD: begin
                                f_d.slot  = BY_DATA;
                                f_d.state = ST_RX;
                            end
                            default: begin
                                f_d.commit = 1'b1;
                                f_d.state  = ST_IGNORE;
                            end
                        endcase
                    end
                end
                default: begin
                    f_d.state = f_q.state;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{state: ST_IDLE, slot: BY_ADDR, default: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign sda_oe_o = (f_q.state == ST_ACK_LO) || (f_q.state == ST_ACK_HI);
    assign commit_o = f_q.commit;
    assign cmd_o    = f_q.cmd;
    assign data_o   = f_q.data;

endmodule

// File: rtl/smb_bw_regs.sv
module smb_bw_regs
    import smb_bw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [BYTE_W-1:0]  cmd_i,
    input  logic [BYTE_W-1:0]  data_i,
    output logic [BYTE_W-1:0]  ctrl_o,
    output logic [BYTE_W-1:0]  msg0_o,
    output logic [BYTE_W-1:0]  msg1_o,
    output logic [STRAP_W-1:0] strap_o,
    output logic               stb_o,
    output logic [BYTE_W-1:0]  idx_o
);

    localparam int NDEST = 4;
    localparam logic [BYTE_W-1:0] DEST_CMD [NDEST] = '{CMD_CTRL, CMD_MSG0, CMD_MSG1, CMD_STRAP};

    reg_bank_t r_d, r_q;
    logic [NDEST-1:0] hit;

    for (genvar g = 0; g < NDEST; g++) begin : g_dec
        assign hit[g] = commit_i && (cmd_i == DEST_CMD[g]);
    end

    always_comb begin
        r_d     = r_q;
        r_d.stb = |hit;
        if (hit[0]) r_d.ctrl  = data_i;
        if (hit[1]) r_d.msg0  = data_i;
        if (hit[2]) r_d.msg1  = data_i;
        if (hit[3]) r_d.strap = data_i[STRAP_W-1:0];
        if (|hit)   r_d.idx   = cmd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_o  = r_q.ctrl;
    assign msg0_o  = r_q.msg0;
    assign msg1_o  = r_q.msg1;
    assign strap_o = r_q.strap;
    assign stb_o   = r_q.stb;
    assign idx_o   = r_q.idx;

endmodule

// File: rtl/smb_bytewr_slave.sv
module smb_bytewr_slave
    import smb_bw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [6:0]  own_addr_i,
    output logic        sda_oe_o,
    output logic [7:0]  cmd_reg_o,
    output logic [7:0]  msg0_o,
    output logic [7:0]  msg1_o,
    output logic [3:0]  strap_o,
    output logic        wr_stb_o,
    output logic [7:0]  wr_idx_o
);

    logic scl_s, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
    logic commit;
    logic [BYTE_W-1:0] cmd_b, data_b;

    smb_bw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .scl_o  (scl_s),
        .sda_o  (sda_s),
        .start_o(start_ev),
        .stop_o (stop_ev),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    smb_bw_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr_i(own_addr_i),
        .sda_s_i   (sda_s),
        .start_i   (start_ev),
        .stop_i    (stop_ev),
        .rise_i    (rise_ev),
        .fall_i    (fall_ev),
        .sda_oe_o  (sda_oe_o),
        .commit_o  (commit),
        .cmd_o     (cmd_b),
        .data_o    (data_b)
    );

    smb_bw_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .cmd_i   (cmd_b),
        .data_i  (data_b),
        .ctrl_o  (cmd_reg_o),
        .msg0_o  (msg0_o),
        .msg1_o  (msg1_o),
        .strap_o (strap_o),
        .stb_o   (wr_stb_o),
        .idx_o   (wr_idx_o)
    );

    logic unused_scl;
    assign unused_scl = scl_s;

endmodule

// File: rtl/smb_bw_chk.sv
module smb_bw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] cmd_reg_o,
    input logic [7:0] msg0_o,
    input logic [3:0] strap_o,
    input logic       wr_stb_o,
    input logic [7:0] wr_idx_o
);

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R11

    AST_STB_LEGAL_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (wr_idx_o == 8'h00 || wr_idx_o == 8'h04 || wr_idx_o == 8'h05 || wr_idx_o == 8'h08)); // R7

    AST_MSG0_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(msg0_o) |-> (wr_stb_o && wr_idx_o == 8'h04)); // R8

    AST_CTRL_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_reg_o) |-> (wr_stb_o && wr_idx_o == 8'h00)); // R5

    AST_STRAP_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strap_o) |-> (wr_stb_o && wr_idx_o == 8'h08)); // R6

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i); // R2

endmodule

bind smb_bytewr_slave smb_bw_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .cmd_reg_o(cmd_reg_o),
    .msg0_o   (msg0_o),
    .strap_o  (strap_o),
    .wr_stb_o (wr_stb_o),
    .wr_idx_o (wr_idx_o)
);

// File: tb/smb_bytewr_slave_tb.sv
module smb_bytewr_slave_tb;

    localparam int HALF = 10;
    localparam logic [6:0] OWN = 7'h2A;
    localparam int NV = 12;
    // {addr[6:0], rw, cmd[7:0], data[7:0]}
    localparam logic [23:0] VEC [NV] = '{
        {7'h2A, 1'b0, 8'h00, 8'h5A},
        {7'h2A, 1'b0, 8'h04, 8'h11},
        {7'h2A, 1'b0, 8'h05, 8'h22},
        {7'h2A, 1'b0, 8'h08, 8'hF7},
        {7'h2A, 1'b0, 8'h04, 8'h33},
        {7'h2A, 1'b0, 8'h03, 8'hEE},
        {7'h2A, 1'b0, 8'h09, 8'hEE},
        {7'h2A, 1'b0, 8'hFF, 8'hEE},
        {7'h2B, 1'b0, 8'h04, 8'h99},
        {7'h2A, 1'b1, 8'h04, 8'h99},
        {7'h2A, 1'b0, 8'h06, 8'hEE},
        {7'h2A, 1'b0, 8'h08, 8'hA3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, wr_stb;
    logic [7:0] cmd_reg, msg0, msg1, wr_idx;
    logic [3:0] strap;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    smb_bytewr_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .own_addr_i(OWN),
        .sda_oe_o  (sda_oe),
        .cmd_reg_o (cmd_reg),
        .msg0_o    (msg0),
        .msg1_o    (msg1),
        .strap_o   (strap),
        .wr_stb_o  (wr_stb),
        .wr_idx_o  (wr_idx)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int stb_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    logic [7:0] last_idx = 8'h00;

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_idx = wr_idx;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; ticks(HALF);
        scl_m = 1'b1; ticks(HALF);
        sda_m = 1'b0; ticks(HALF);
        scl_m = 1'b0; ticks(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; ticks(HALF);
        scl_m = 1'b1; ticks(HALF);
        sda_m = 1'b1; ticks(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    ticks(HALF);
        scl_m = 1'b1; ticks(HALF);
        scl_m = 1'b0; ticks(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; ticks(HALF);
        scl_m = 1'b1; ticks(HALF / 2);
        ack = !sda_line;
        ticks(HALF - HALF / 2);
        scl_m = 1'b0; ticks(8);
    endtask

    logic [7:0] m_cmd = 8'h00, m_msg0 = 8'h00, m_msg1 = 8'h00;
    logic [3:0] m_strap = 4'h0;

    task automatic check_regs(input string tag);
        check({tag, " cmd_reg"}, int'(cmd_reg), int'(m_cmd));
        check({tag, " msg0"},    int'(msg0),    int'(m_msg0));
        check({tag, " msg1"},    int'(msg1),    int'(m_msg1));
        check({tag, " strap"},   int'(strap),   int'(m_strap));
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        int s0;
        ticks(5);
        // R1 reset state
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 wr_stb", int'(wr_stb), 0);
        check_regs("R1");
        rst_n = 1'b1;
        ticks(5);

        for (int v = 0; v < NV; v++) begin
            logic [6:0] ad;
            logic       rw;
            logic [7:0] cm, da;
            logic       match;
            int         exp_stb;
            {ad, rw, cm, da} = VEC[v];
            match   = (ad == OWN) && !rw;
            exp_stb = 0;
            s0 = stb_cnt;
            bus_start();
            send_byte({ad, rw}, a0);
            check(match ? "R2 addr ack" : (rw ? "R4 read nack" : "R3 mismatch nack"), int'(a0), int'(match));
            if (a0) begin
                send_byte(cm, a1);
                check("R2 cmd ack", int'(a1), 1);
                send_byte(da, a2);
                check("R2 data ack", int'(a2), 1);
            end
            bus_stop();
            ticks(5);
            if (match) begin
                case (cm)
                    8'h00: begin m_cmd = da; exp_stb = 1; end
                    8'h04: begin m_msg0 = da; exp_stb = 1; end
                    8'h05: begin m_msg1 = da; exp_stb = 1; end
                    8'h08: begin m_strap = da[3:0]; exp_stb = 1; end
                    default: exp_stb = 0;
                endcase
            end
            // R5 R6 R7 R8 stored values; R3 R4 unchanged on no-ack
            check_regs(match ? (exp_stb != 0 ? "R5/R6/R8 store" : "R7 reserved") : "R3/R4 no change");
            check("R11 strobe count", stb_cnt - s0, exp_stb);
            if (exp_stb != 0) check("R11 strobe idx", int'(last_idx), int'(cm));
        end

        // R9 stop during data byte discards
        s0 = stb_cnt;
        bus_start();
        send_byte({OWN, 1'b0}, a0);
        send_byte(8'h05, a1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        ticks(5);
        check_regs("R9 aborted");
        check("R9 no strobe", stb_cnt - s0, 0);

        // R10 repeated start after mismatched address
        bus_start();
        send_byte({7'h11, 1'b0}, a0);
        check("R10 mismatch nack", int'(a0), 0);
        bus_start();
        send_byte({OWN, 1'b0}, a0);
        send_byte(8'h00, a1);
        send_byte(8'hC3, a2);
        bus_stop();
        ticks(5);
        m_cmd = 8'hC3;
        check("R10 ack after restart", int'(a0 & a1 & a2), 1);
        check_regs("R10 after mismatch");

        // R10 repeated start in the middle of the command byte
        bus_start();
        send_byte({OWN, 1'b0}, a0);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        bus_start();
        send_byte({OWN, 1'b0}, a0);
        send_byte(8'h05, a1);
        send_byte(8'h6D, a2);
        bus_stop();
        ticks(5);
        m_msg1 = 8'h6D;
        check_regs("R10 mid-command");

        // R11 strobe width
        check("R11 strobe width", max_run, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule